// File: doc/BRIEF.md
# Time-of-Day Seconds/Minutes/Hours Unit

This block keeps the time of day for a real-time clock. A prescaler counts enable pulses from a 32.768 kHz source and, once per second, advances the seconds, minutes and hours registers. Each update raises a one-cycle update-ended pulse. When the alarm fields match the new time, an alarm pulse is raised in the same cycle. A day-carry pulse marks the hour rollover so that a separate calendar block can advance the date.

Software picks either packed BCD or plain binary storage, and either a 24-hour or a 12-hour format with a PM flag. It loads the time and alarm fields through a simple write port. A freeze control stops the clock from advancing while software sets the time. A divider-hold code parks the prescaler at its half-second point. An update-in-progress flag is raised during the last few ticks before each update. No data stream passes through this block, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `rtc_tod_unit`

## Requirements
- R1: With `fmt_binary`=0, every time and alarm byte is packed BCD, with the tens digit in bits 7:4 and the units in bits 3:0. With `fmt_binary`=1, every byte holds the plain binary value.
- R2: Seconds and minutes count 0 to 59. An update at 59 seconds gives 0 and carries one into minutes. A carry into minutes at 59 gives 0 and carries one into hours.
- R3: In 24-hour mode (`fmt_24h`=1), hours count 0 to 23. The carry out of 23 gives 0 and asserts `day_carry` in the same cycle as `uf_set`.
- R4: In 12-hour mode, bit 7 of the hours byte is the PM flag, and the hour runs 12, 1, 2 up to 11. The step from 11 to 12 toggles PM. The step from 12 gives 1 and leaves PM unchanged. `day_carry` is raised only on the step from 11 PM to 12 AM.
- R5: Each second update asserts `uf_set` for exactly one clock cycle. The new time is visible on the time outputs in that same cycle.
- R6: `af_set` is asserted together with `uf_set` when each of the three alarm bytes either equals the new time byte or has bits 7:6 equal to 11, which means "any value".
- R7: While `set_freeze`=1, the time does not advance and neither `uf_set` nor `af_set` is raised. Writes are still accepted.
- R8: `uip` is 1 during the last UIP_TICKS prescaler counts before an update, and 0 otherwise. `uip` is forced to 0 while `set_freeze`=1 or while the divider is not running.
- R9: When `div_ctl`[2:1]=11, the prescaler is held at its half-second point and no update occurs. When `div_ctl` is then changed to a running code (a value of 010 or less), the first update follows after 2^(PRESCALE_BITS-1) ticks.
- R10: While the divider is running, updates come every 2^PRESCALE_BITS ticks.
- R11: `wr_sel` selects the target of a write: 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours. A write with `wr_en`=1 stores `wr_data` at the next clock edge. If an update falls in the same cycle, the write takes priority for the selected field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz period |
| set_freeze | input | 1 | Freeze time updates while software sets the time |
| fmt_binary | input | 1 | 1 = binary storage, 0 = packed BCD |
| fmt_24h | input | 1 | 1 = 24-hour format, 0 = 12-hour format with PM flag |
| div_ctl | input | 3 | Divider control; 11x holds the prescaler, 000 to 010 lets it run |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| sec_q | output | 8 | Seconds byte |
| min_q | output | 8 | Minutes byte |
| hour_q | output | 8 | Hours byte |
| uip | output | 1 | Update-in-progress flag |
| uf_set | output | 1 | Update-ended pulse |
| af_set | output | 1 | Alarm pulse |
| day_carry | output | 1 | Hour rollover pulse |

## Verification
A prescaler phase error shows at the ports within one second. Either the gap between `uf_set` pulses differs from 2^PRESCALE_BITS ticks, or `uip` rises at the wrong tick count before the pulse. A wrong carry or encoding step shows on the time bytes at the very next update, so rollovers are set up one second ahead of the boundary. An alarm comparison fault appears as a missing or extra `af_set` on that same update pulse.

// File: rtl/rtc_tod_pkg.sv
`timescale 1ns/1ps
package rtc_tod_pkg;
  localparam logic [2:0] SEL_SEC   = 3'd0;
  localparam logic [2:0] SEL_MIN   = 3'd1;
  localparam logic [2:0] SEL_HOUR  = 3'd2;
  localparam logic [2:0] SEL_ASEC  = 3'd3;
  localparam int         ALARM_FIELDS = 3;

  // stored byte -> numeric value
  function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
    if (bin) return b[6:0];
    return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
  endfunction

  // numeric value -> stored byte
  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - (tens * 7'd10);
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int PRESCALE_BITS = 15,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       freeze,
  input  logic [2:0] div_ctl,
  output logic       sec_strobe,
  output logic       uip
);
  localparam logic [PRESCALE_BITS-1:0] CNT_MAX   = {PRESCALE_BITS{1'b1}};
  localparam logic [PRESCALE_BITS-1:0] CNT_HALF  = CNT_MAX ^ (CNT_MAX >> 1);
  localparam logic [PRESCALE_BITS-1:0] UIP_START = CNT_MAX - PRESCALE_BITS'(UIP_TICKS - 1);

  logic [PRESCALE_BITS-1:0] cnt_q;
  logic div_hold;
  logic div_run;

  assign div_hold = (div_ctl[2:1] == 2'b11);
  assign div_run  = (div_ctl <= 3'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (div_hold)        cnt_q <= CNT_HALF;
    else if (div_run && tick) cnt_q <= cnt_q + 1'b1;
  end

  assign sec_strobe = div_run && tick && !freeze && (cnt_q == CNT_MAX);
  assign uip        = div_run && !freeze && (cnt_q >= UIP_START);

  AST_STROBE_IN_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> uip); // R8
endmodule

// File: rtl/rtc_time_counter.sv
`timescale 1ns/1ps
module rtc_time_counter
  import rtc_tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       fmt_binary,
  input  logic       fmt_24h,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] sec_nx,
  output logic [7:0] min_nx,
  output logic [7:0] hour_nx,
  output logic       day_wrap
);
  logic [6:0] sec_d, min_d, hour_d;
  logic       sec_end, min_end;
  logic [6:0] hour_v;
  logic       pm_v;

  always_comb begin
    sec_d   = dec_val(sec_q, fmt_binary);
    min_d   = dec_val(min_q, fmt_binary);
    hour_d  = dec_val({1'b0, hour_q[6:0]}, fmt_binary);
    sec_end = (sec_d >= 7'd59);
    min_end = sec_end && (min_d >= 7'd59);

    sec_nx  = enc_val(sec_end ? 7'd0 : sec_d + 7'd1, fmt_binary);
    min_nx  = sec_end ? enc_val((min_d >= 7'd59) ? 7'd0 : min_d + 7'd1, fmt_binary) : min_q;

    hour_v   = hour_d;
    pm_v     = hour_q[7];
    day_wrap = 1'b0;
    if (fmt_24h) begin
      pm_v = 1'b0;
      if (hour_d >= 7'd23) begin
        hour_v   = 7'd0;
        day_wrap = min_end;
      end else begin
        hour_v = hour_d + 7'd1;
      end
    end else begin
      if (hour_d >= 7'd12) begin
        hour_v = 7'd1;
      end else if (hour_d == 7'd11) begin
        hour_v   = 7'd12;
        pm_v     = ~hour_q[7];
        day_wrap = min_end && hour_q[7];
      end else begin
        hour_v = hour_d + 7'd1;
      end
    end
    if (min_end) begin
      hour_nx = enc_val(hour_v, fmt_binary);
      if (!fmt_24h) hour_nx[7] = pm_v;
    end else begin
      hour_nx = hour_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else begin
      if (advance) begin
        sec_q  <= sec_nx;
        min_q  <= min_nx;
        hour_q <= hour_nx;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_SEC:  sec_q  <= wr_data;
          SEL_MIN:  min_q  <= wr_data;
          SEL_HOUR: hour_q <= wr_data;
          default:  ;
        endcase
      end
    end
  end

  AST_DAY_ONLY_ON_ZERO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && day_wrap && !wr_en) |=> (min_q == 8'h00)); // R3
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
  import rtc_tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [7:0] sec_nx,
  input  logic [7:0] min_nx,
  input  logic [7:0] hour_nx,
  output logic       match
);
  logic [7:0] cur [ALARM_FIELDS];
  logic [ALARM_FIELDS-1:0] hit;

  assign cur[0] = sec_nx;
  assign cur[1] = min_nx;
  assign cur[2] = hour_nx;

  for (genvar g = 0; g < ALARM_FIELDS; g++) begin : g_field
    logic [7:0] alarm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alarm_q <= '0;
      else if (wr_en && (wr_sel == SEL_ASEC + 3'(g))) alarm_q <= wr_data;
    end
    assign hit[g] = (alarm_q[7:6] == 2'b11) || (alarm_q == cur[g]);
  end

  assign match = &hit;
endmodule

// File: rtl/rtc_tod_unit.sv
`timescale 1ns/1ps
module rtc_tod_unit #(
  parameter int PRESCALE_BITS = 15,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       set_freeze,
  input  logic       fmt_binary,
  input  logic       fmt_24h,
  input  logic [2:0] div_ctl,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       uip,
  output logic       uf_set,
  output logic       af_set,
  output logic       day_carry
);
  logic       strobe;
  logic [7:0] sec_nx, min_nx, hour_nx;
  logic       day_wrap;
  logic       alarm_hit;

  rtc_prescaler #(.PRESCALE_BITS(PRESCALE_BITS), .UIP_TICKS(UIP_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_32k), .freeze(set_freeze),
    .div_ctl(div_ctl), .sec_strobe(strobe), .uip(uip)
  );

  rtc_time_counter u_time (
    .clk(clk), .rst_n(rst_n), .advance(strobe),
    .fmt_binary(fmt_binary), .fmt_24h(fmt_24h),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
    .sec_nx(sec_nx), .min_nx(min_nx), .hour_nx(hour_nx),
    .day_wrap(day_wrap)
  );

  rtc_alarm_match u_alarm (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_nx(sec_nx), .min_nx(min_nx), .hour_nx(hour_nx),
    .match(alarm_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_set    <= 1'b0;
      af_set    <= 1'b0;
      day_carry <= 1'b0;
    end else begin
      uf_set    <= strobe;
      af_set    <= strobe && alarm_hit;
      day_carry <= strobe && day_wrap;
    end
  end

  AST_UF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    uf_set |=> !uf_set); // R5
  AST_AF_WITH_UF: assert property (@(posedge clk) disable iff (!rst_n)
    af_set |-> uf_set); // R6
  AST_DAY_WITH_UF: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> uf_set); // R3
  AST_FREEZE_HOLDS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (set_freeze && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) && !uf_set)); // R7
  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |=> !uf_set); // R9
endmodule

// File: tb/sim_rtc_tod_unit.sv
`timescale 1ns/1ps
module sim_rtc_tod_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       set_freeze = 1'b0;
  logic       fmt_binary = 1'b0;
  logic       fmt_24h = 1'b1;
  logic [2:0] div_ctl = 3'b010;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_q, min_q, hour_q;
  logic       uip, uf_set, af_set, day_carry;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  rtc_tod_unit #(.PRESCALE_BITS(6), .UIP_TICKS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .set_freeze(set_freeze),
    .fmt_binary(fmt_binary), .fmt_24h(fmt_24h), .div_ctl(div_ctl),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
    .uip(uip), .uf_set(uf_set), .af_set(af_set), .day_carry(day_carry)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick_32k = 1'b1;
    @(negedge clk) tick_32k = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  task automatic wait_update(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      tick_once();
      n++;
      if (uf_set) break;
    end
  endtask

  task automatic t_reset();
    check("R5 reset uf", int'(uf_set), 0);
    check("R8 reset uip", int'(uip), 0);
    check("R2 reset sec", int'(sec_q), 0);
    check("R3 reset hour", int'(hour_q), 0);
  endtask

  task automatic t_freeze();
    int bad = 0;
    set_freeze = 1'b1;
    set_time(8'h23, 8'h59, 8'h58);
    check("R11 write readback", int'(sec_q), 8'h58);
    for (int i = 0; i < 80; i++) begin
      tick_once();
      if (uf_set || af_set || uip) bad++;
    end
    check("R7 no uf/af/uip in freeze", bad, 0);
    check("R7 time held", int'({hour_q, min_q, sec_q}), 24'h235958);
    set_freeze = 1'b0;
  endtask

  task automatic t_rollover_24();
    int n;
    wait_update(n);
    check("R2 sec advance", int'({hour_q, min_q, sec_q}), 24'h235959);
    check("R3 no carry mid-day", int'(day_carry), 0);
    wait_update(n);
    check("R10 period ticks", n, 64);
    check("R3 wrap to midnight", int'({hour_q, min_q, sec_q}), 24'h000000);
    check("R3 day carry", int'(day_carry), 1);
    check("R6 exact alarm match", int'(af_set), 1);
    @(negedge clk);
    check("R5 uf one cycle", int'(uf_set), 0);
  endtask

  task automatic t_uip();
    for (int i = 0; i < 55; i++) tick_once();
    check("R8 uip low early", int'(uip), 0);
    tick_once();
    check("R8 uip high in window", int'(uip), 1);
    @(negedge clk) set_freeze = 1'b1;
    #1 check("R8 freeze clears uip", int'(uip), 0);
    @(negedge clk) set_freeze = 1'b0;
    #1 check("R8 uip back", int'(uip), 1);
    for (int i = 0; i < 7; i++) tick_once();
    check("R8 uip last tick", int'(uip), 1);
    check("R10 no early update", int'(uf_set), 0);
    tick_once();
    check("R5 update at window end", int'(uf_set), 1);
    check("R8 uip after update", int'(uip), 0);
  endtask

  task automatic t_binary();
    int n;
    fmt_binary = 1'b1;
    set_time(8'h05, 8'h3B, 8'h3B);
    wait_update(n);
    check("R1 binary rollover", int'({hour_q, min_q, sec_q}), 24'h060000);
    check("R1 no day carry", int'(day_carry), 0);
    fmt_binary = 1'b0;
  endtask

  task automatic t_12h();
    int n;
    fmt_24h = 1'b0;
    set_time(8'h91, 8'h59, 8'h59);
    wait_update(n);
    check("R4 11PM to 12AM", int'({hour_q, min_q, sec_q}), 24'h120000);
    check("R4 day carry at midnight", int'(day_carry), 1);
    set_time(8'h11, 8'h59, 8'h59);
    wait_update(n);
    check("R4 11AM to 12PM", int'(hour_q), 8'h92);
    check("R4 no carry at noon", int'(day_carry), 0);
    set_time(8'h12, 8'h59, 8'h59);
    wait_update(n);
    check("R4 12 to 1", int'(hour_q), 8'h01);
    fmt_24h = 1'b1;
  endtask

  task automatic t_alarm();
    int n;
    set_time(8'h07, 8'h10, 8'h04);
    wr(3'd5, 8'hC0); wr(3'd4, 8'hC0); wr(3'd3, 8'h05);
    wait_update(n);
    check("R6 dont-care alarm fires", int'(af_set), 1);
    wait_update(n);
    check("R6 no alarm on mismatch", int'(af_set), 0);
    check("R5 uf on mismatch", int'(uf_set), 1);
    wr(3'd3, 8'hFF);
    wait_update(n);
    check("R6 all dont-care", int'(af_set), 1);
  endtask

  task automatic t_hold();
    int n;
    int bad = 0;
    div_ctl = 3'b110;
    for (int i = 0; i < 150; i++) begin
      tick_once();
      if (uf_set || uip) bad++;
    end
    check("R9 hold blocks update", bad, 0);
    div_ctl = 3'b010;
    wait_update(n);
    check("R9 half second after release", n, 32);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_freeze();
    t_rollover_24();
    t_uip();
    t_binary();
    t_12h();
    t_alarm();
    t_hold();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule